// File: doc/BRIEF.md
# Strobe-Controlled FIFO with Edge-Timed Flags

This block is a first-in first-out store of 1024 nine-bit words. It is driven by two active-low strobes, one for writing and one for reading, instead of clock enables. Both strobes are brought into the system clock domain through a short synchronizer. Their falling and rising transitions are then detected, and each transition counts as one event. The output data bus is qualified by an output-enable that takes the place of a high-impedance state. When no read is in progress, the data bus is held at zero.

A write is reserved on the falling write edge and stored on the rising write edge. A read presents the oldest word from its falling edge and removes that word on its rising edge. The empty, half-full and full flags are all active low. Each flag is set and cleared on a specific strobe edge. A read strobe held low on an empty store waits for the next stored word, which gives read flow-through. A write strobe held low on a full store waits for a freed location, which gives write flow-through.

Top module: `strobe_fifo`

## Requirements
- R1: Words leave in the order they were written. The store holds 1024 words of 9 bits, and the pointers wrap modulo 1024.
- R2: While `rst_n` is low, the store is emptied and `empty_n`=0, `half_n`=1, `full_n`=1, `dout_oe`=0, `dout`=0.
- R3: A read strobe falling while at least one word is stored sets `dout_oe`=1 and shows the oldest word on `dout`. The read's rising edge clears `dout_oe`, sets `dout` to 0 and removes that word.
- R4: A write strobe that falls while the store is full and rises before room appears stores nothing. Data is taken from `din` when the rising write edge is detected.
- R5: `empty_n` goes low when a falling read edge claims the last stored word. It goes high when a rising write edge stores a word while no read holds all stored words.
- R6: `full_n` goes low when a falling write edge reserves the last free location. It goes high when a rising read edge frees one. The occupancy never exceeds 1024.
- R7: `half_n` goes low when a falling write edge takes the reserved occupancy above 512. It goes high when a rising read edge brings the occupancy to 512 or below.
- R8: A read strobe held low on an empty store shows the first word written afterwards, and `empty_n` is high for exactly one cycle before that read claims the word. Further writes during the same low read do not change `dout`.
- R9: A write strobe held low on a full store is accepted one cycle after a read frees a location. `full_n` is high for exactly one cycle, and the word is stored on the write's rising edge.
- R10: A read completion and a write completion detected in the same cycle are both performed, and the occupancy is unchanged.
- R11: A strobe level change takes effect on the outputs at the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| din | input | 9 | Write data |
| dout | output | 9 | Read data, zero when not enabled |
| dout_oe | output | 1 | Read data valid / drive enable |
| empty_n | output | 1 | Active-low empty flag |
| half_n | output | 1 | Active-low half-full flag |
| full_n | output | 1 | Active-low full flag |

## Verification
Every strobe transition reaches the outputs at the third rising clock edge after it. Two of those edges are spent in the synchronizer, and the third loads the control state. The bench drives strobes on falling clock edges and keeps a behavioural queue model that runs through the same three-edge delay. It compares every output on every falling edge, half a period after the results settle. The flow-through tests count the single cycle in which a flag is released. The latency test samples just before and just after the third edge.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  typedef struct packed {
    logic fall;
    logic rise;
  } strobe_ev_t;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
  import strobe_fifo_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_n,
  output strobe_ev_t ev
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], strobe_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  always_comb begin
    ev.fall = sh_q[STAGES] & ~sh_q[STAGES-1];
    ev.rise = ~sh_q[STAGES] & sh_q[STAGES-1];
  end
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DEPTH = 1024,
  parameter int W     = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_ev_t    wr_ev,
  input  strobe_ev_t    rd_ev,
  output logic          wr_commit,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] cnt,
  output logic          wr_act,
  output logic          rd_act
);
  logic          wr_req_q, wr_req_d, wr_act_d;
  logic          rd_req_q, rd_req_d, rd_act_d;
  logic [AW-1:0] wptr_d, rptr_d;
  logic [CW-1:0] cnt_d;
  logic          rd_commit;

  assign wr_commit = wr_ev.rise & wr_act;
  assign rd_commit = rd_ev.rise & rd_act;

  always_comb begin
    wr_req_d = wr_req_q;
    wr_act_d = wr_act;
    if (wr_ev.rise) begin
      wr_req_d = 1'b0;
      wr_act_d = 1'b0;
    end else begin
      if (wr_ev.fall) wr_req_d = 1'b1;
      if ((wr_req_q | wr_ev.fall) & ~wr_act & (cnt != CW'(DEPTH))) wr_act_d = 1'b1;
    end

    rd_req_d = rd_req_q;
    rd_act_d = rd_act;
    if (rd_ev.rise) begin
      rd_req_d = 1'b0;
      rd_act_d = 1'b0;
    end else begin
      if (rd_ev.fall) rd_req_d = 1'b1;
      if ((rd_req_q | rd_ev.fall) & ~rd_act & (cnt != '0)) rd_act_d = 1'b1;
    end

    wptr_d = wr_commit ? wptr + AW'(1) : wptr;
    rptr_d = rd_commit ? rptr + AW'(1) : rptr;
    cnt_d  = cnt + CW'(wr_commit) - CW'(rd_commit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_req_q <= 1'b0;
      wr_act   <= 1'b0;
      rd_req_q <= 1'b0;
      rd_act   <= 1'b0;
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
    end else begin
      wr_req_q <= wr_req_d;
      wr_act   <= wr_act_d;
      rd_req_q <= rd_req_d;
      rd_act   <= rd_act_d;
      wptr     <= wptr_d;
      rptr     <= rptr_d;
      cnt      <= cnt_d;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_ptr_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr - rptr) == cnt[AW-1:0]);
  assert_read_has_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_act) |-> $past(cnt) != '0);
  assert_write_has_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_act) |-> $past(cnt) != CW'(DEPTH));
  assert_unit_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1)) || (cnt + CW'(1) == $past(cnt)));
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH       = 1024,
  parameter int W           = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_n,
  input  logic         rd_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_oe,
  output logic         empty_n,
  output logic         half_n,
  output logic         full_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  strobe_ev_t    wr_ev, rd_ev;
  logic          wr_commit, wr_act, rd_act;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, reserved;
  logic [W-1:0]  rdata;

  strobe_edge #(.STAGES(SYNC_STAGES)) u_wr_edge (
    .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .ev(wr_ev));
  strobe_edge #(.STAGES(SYNC_STAGES)) u_rd_edge (
    .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .ev(rd_ev));

  fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .rd_ev(rd_ev),
    .wr_commit(wr_commit), .wptr(wptr), .rptr(rptr), .cnt(cnt),
    .wr_act(wr_act), .rd_act(rd_act));

  fifo_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .we(wr_commit), .waddr(wptr), .wdata(din),
    .raddr(rptr), .rdata(rdata));

  // occupancy including a write reserved on its falling edge
  assign reserved = cnt + CW'(wr_act);

  always_comb begin
    full_n  = ~(reserved == CW'(DEPTH));
    half_n  = ~(reserved > CW'(DEPTH / 2));
    empty_n = ~(cnt == CW'(rd_act));
    dout_oe = rd_act;
    dout    = rd_act ? rdata : '0;
  end

  assert_oe_backed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> cnt != '0);
  assert_full_implies_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !half_n);
  assert_empty_not_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_n && !full_n));
endmodule

// File: tb/sim_strobe_fifo.sv
module sim_strobe_fifo;
  logic       clk;
  logic       rst_n;
  logic       wr_n, rd_n;
  logic [8:0] din;
  logic [8:0] dout;
  logic       dout_oe, empty_n, half_n, full_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  strobe_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .empty_n(empty_n), .half_n(half_n),
    .full_n(full_n));

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [8:0] q[$];
  bit m_wreq, m_wact, m_rreq, m_ract;
  bit [2:0] hw, hr;
  bit wf, wrs, rf, rrs, nw, nr;
  int sz;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_wreq = 0; m_wact = 0; m_rreq = 0; m_ract = 0;
      hw = 3'b111; hr = 3'b111;
    end else begin
      wf  = hw[2] & ~hw[1];
      wrs = ~hw[2] & hw[1];
      rf  = hr[2] & ~hr[1];
      rrs = ~hr[2] & hr[1];
      sz  = q.size();
      nw  = m_wact;
      nr  = m_ract;
      if (wrs) begin
        if (m_wact) q.push_back(din);
        m_wreq = 0; nw = 0;
      end else begin
        if (wf) m_wreq = 1;
        if (m_wreq && !m_wact && sz < 1024) nw = 1;
      end
      if (rrs) begin
        if (m_ract) void'(q.pop_front());
        m_rreq = 0; nr = 0;
      end else begin
        if (rf) m_rreq = 1;
        if (m_rreq && !m_ract && sz != 0) nr = 1;
      end
      m_wact = nw;
      m_ract = nr;
      hw = {hw[1:0], wr_n};
      hr = {hr[1:0], rd_n};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 empty_n", empty_n, (q.size() != int'(m_ract)) ? 1 : 0);
      chk("R6 full_n",  full_n,  (q.size() + int'(m_wact) == 1024) ? 0 : 1);
      chk("R7 half_n",  half_n,  (q.size() + int'(m_wact) > 512) ? 0 : 1);
      chk("R3 dout_oe", dout_oe, m_ract);
      chk("R1 dout",    dout,    (m_ract && q.size() > 0) ? q[0] : 0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr_pulse(input logic [8:0] d);
    @(negedge clk); din = d; wr_n = 0;
    repeat (4) @(negedge clk); wr_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_pulse();
    @(negedge clk); rd_n = 0;
    repeat (4) @(negedge clk); rd_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int pulses, n;
    rst_n = 0; wr_n = 1; rd_n = 1; din = 0;
    repeat (3) @(negedge clk);
    chk("R2 empty_n", empty_n, 0);
    chk("R2 half_n", half_n, 1);
    chk("R2 full_n", full_n, 1);
    chk("R2 dout_oe", dout_oe, 0);
    chk("R2 dout", dout, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R11: latency of a rising write edge to the empty flag
    din = 9'h0A5; wr_n = 0;
    repeat (6) @(negedge clk);
    wr_n = 1;
    repeat (2) @(negedge clk);
    chk("R11 empty_n before third edge", empty_n, 0);
    @(negedge clk);
    chk("R11 empty_n after third edge", empty_n, 1);
    repeat (3) @(negedge clk);
    rd_pulse();
    chk("R5 empty after last read", empty_n, 0);
    chk("R3 oe off after read", dout_oe, 0);

    // fill to capacity, watching R7 and R6
    for (int i = 0; i < 1024; i++) begin
      wr_pulse(9'((i * 37 + 5) & 511));
      if (i == 511) chk("R7 half_n at 512 words", half_n, 1);
      if (i == 512) chk("R7 half_n at 513 words", half_n, 0);
    end
    chk("R6 full_n at 1024 words", full_n, 0);

    // R4: a write started and ended while full is dropped
    wr_pulse(9'h1FF);
    chk("R4 full_n after dropped write", full_n, 0);

    // R9: write held low on a full store
    @(negedge clk); din = 9'h155; wr_n = 0;
    repeat (8) @(negedge clk);
    rd_n = 0;
    repeat (4) @(negedge clk);
    rd_n = 1;
    pulses = 0;
    repeat (12) begin
      @(negedge clk);
      if (full_n) pulses++;
    end
    chk("R9 full_n release cycles", pulses, 1);
    wr_n = 1;
    repeat (8) @(negedge clk);
    chk("R9 full_n after held write stored", full_n, 0);

    // drain, checking half-flag release (R7) and word count (R4)
    n = 0;
    while (empty_n && n < 1100) begin
      rd_pulse();
      n++;
      if (n == 511) chk("R7 half_n at 513 left", half_n, 0);
      if (n == 512) chk("R7 half_n at 512 left", half_n, 1);
    end
    chk("R4 words drained", n, 1024);

    // R8: read held low on an empty store
    @(negedge clk); rd_n = 0;
    repeat (8) @(negedge clk);
    chk("R8 oe while waiting", dout_oe, 0);
    wr_pulse(9'h0C3);
    chk("R8 oe after write", dout_oe, 1);
    chk("R8 first word shown", dout, 9'h0C3);
    wr_pulse(9'h03C);
    chk("R8 later write not shown", dout, 9'h0C3);
    rd_n = 1;
    repeat (8) @(negedge clk);
    @(negedge clk); rd_n = 0;
    repeat (4) @(negedge clk);
    chk("R8 toggled read shows next", dout, 9'h03C);
    rd_n = 1;
    repeat (6) @(negedge clk);
    chk("R5 empty after flow-through", empty_n, 0);

    // R10: simultaneous read and write completion
    wr_pulse(9'h011);
    wr_pulse(9'h022);
    @(negedge clk); rd_n = 0; din = 9'h033; wr_n = 0;
    repeat (6) @(negedge clk);
    rd_n = 1; wr_n = 1;
    repeat (8) @(negedge clk);
    n = 0;
    while (empty_n && n < 10) begin
      rd_pulse();
      n++;
    end
    chk("R10 words after simultaneous completion", n, 2);

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule